// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:2:0 Sub-block Framer

This block sits at the chroma input of an intra-only video encoder. It takes one 8-bit chroma sample per valid cycle, in raster order, where each 4:2:2 line carries blue-difference and red-difference samples alternately. It reduces the stream to 4:2:0 by keeping every other line, stores the kept lines of one 16-line strip, and then separates the two colour components. For every 16-pixel-wide macroblock column it produces one 8x8 blue-difference block and one 8x8 red-difference block. Each block is delivered as four 4x4 sub-blocks, one per cycle, on a wide output with a valid flag and tags that name the component and the quadrant.

The kept lines go into a small line store. Once the last kept line of a strip has arrived, a reader walks the stored columns left to right and shifts them into an 8-row by 16-sample window of interleaved samples. Each full window is copied to a hold register, and an emitter then slices the hold register into the eight sub-blocks. The reader runs while the discarded last line of the strip is arriving, so input can run at one sample per cycle with no back-pressure. Image width and height are multiples of 16, and the width may not exceed the `MAX_W` parameter.

Top module: `chroma_420_framer`

## Requirements
- R1: After reset, `blk_valid_o`, `blk_comp_o` and `blk_sub_o` are 0, and no sub-block is emitted until a strip has been completed.
- R2: Counting sample positions from 0 at the start of each line, even positions go to the blue-difference block and odd positions to the red-difference block. Column j of macroblock column k uses position 16k+2j for blue and 16k+2j+1 for red.
- R3: Only lines 0, 2, ..., 14 of each 16-line strip are used, and block row r comes from strip line 2r. The sample values on odd lines have no effect on any output.
- R4: Each macroblock column yields eight sub-blocks on eight consecutive cycles: the four blue ones first, then the four red ones. `blk_comp_o` is 0 for blue and 1 for red. `blk_sub_o` is 0 for top-left, 1 for top-right, 2 for bottom-left and 3 for bottom-right. `blk_valid_o` is low in the cycle after the last red sub-block.
- R5: Row r, column c of a sub-block is placed at `blk_data_o[8*(4*r+c) +: 8]`.
- R6: Within a strip, macroblock columns are emitted left to right, hres/16 of them per strip. Strips are emitted top to bottom, vres/16 of them per frame. A strip produces output only after the last sample of its line 14 has been accepted.
- R7: A rising edge of `frame_start_i` resets the position to line 0, sample 0, and a valid sample in that same cycle is taken as sample 0. Holding `frame_start_i` high for more cycles does not restart the position again.
- R8: Samples with `c_valid_i` high are ignored after a `frame_end_i` pulse, and after the last sample of line vres-1, until the next rising edge of `frame_start_i`.
- R9: Idle cycles (`c_valid_i` low) anywhere in a frame do not change the emitted data or its order.
- R10: Input at one sample every cycle, with lines and strips back to back, is accepted without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| c_data_i | input | PIX_W | Interleaved chroma sample |
| c_valid_i | input | 1 | Sample qualifier |
| frame_start_i | input | 1 | Frame start; the rising edge is what counts |
| frame_end_i | input | 1 | Frame end pulse |
| hres_i | input | 16 | Samples per line, a multiple of 16 and at most MAX_W |
| vres_i | input | 16 | Lines per frame, a multiple of 16 |
| blk_valid_o | output | 1 | Sub-block valid |
| blk_comp_o | output | 1 | Component tag: 0 blue, 1 red |
| blk_sub_o | output | 2 | Quadrant within the 8x8 block, in raster order |
| blk_data_o | output | 16*PIX_W | 4x4 sub-block, row-major |

## Verification
The bench gives every sample a value that depends on its line and position, and gives odd lines an unrelated pattern. A design that swapped the components, kept the wrong field of lines, or mis-sliced the window therefore produces data that fails the compare against the expected sub-blocks. A restart test sends part of a frame with `frame_start_i` held high, then raises it again. A design that restarts on the level, or ignores the new edge, emits misaligned data. Samples sent after the end of a frame, and after an explicit end pulse, are long enough to complete a whole strip, so a design that accepted them would emit extra sub-blocks and fail the count. Stalled input and a wide frame at full rate with back-to-back strips catch a reader that overlaps the next strip's writes or drops columns.

// File: rtl/chroma_framer_pkg.sv
package chroma_framer_pkg;
  localparam int MB_W   = 16;  // interleaved chroma samples per macroblock column
  localparam int C_ROWS = 8;   // kept lines per strip
  localparam int SUB_N  = 4;   // sub-block edge

  typedef enum logic {
    COMP_CB = 1'b0,
    COMP_CR = 1'b1
  } comp_e;
endpackage

// File: rtl/chroma_line_store.sv
module chroma_line_store #(
  parameter int PIX_W = 8,
  parameter int MAX_W = 64,
  parameter int ROWS  = 8,
  localparam int XW = $clog2(MAX_W),
  localparam int RW = $clog2(ROWS)
) (
  input  logic                  clk_i,
  input  logic                  wr_en_i,
  input  logic [RW-1:0]         wr_row_i,
  input  logic [XW-1:0]         wr_col_i,
  input  logic [PIX_W-1:0]      wr_data_i,
  input  logic [XW-1:0]         rd_col_i,
  output logic [ROWS*PIX_W-1:0] rd_data_o
);
  logic [PIX_W-1:0] mem [ROWS][MAX_W];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_row_i][wr_col_i] <= wr_data_i;
  end

  // whole column across all kept lines
  for (genvar r = 0; r < ROWS; r++) begin : g_rd
    assign rd_data_o[r*PIX_W +: PIX_W] = mem[r][rd_col_i];
  end
endmodule

// File: rtl/chroma_window.sv
module chroma_window #(
  parameter int PIX_W = 8,
  parameter int MAX_W = 64,
  parameter int ROWS  = 8,
  parameter int MB_W  = 16,
  localparam int XW = $clog2(MAX_W),
  localparam int MW = $clog2(MB_W),
  localparam int RW_BITS = MB_W*PIX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [15:0]             last_col_i,
  input  logic [ROWS*PIX_W-1:0]   col_data_i,
  output logic [XW-1:0]           rd_col_o,
  output logic                    busy_o,
  output logic                    load_o,
  output logic [ROWS*RW_BITS-1:0] hold_o
);
  logic          busy_q;
  logic [XW-1:0] col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      col_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      col_q  <= '0;
    end else if (busy_q) begin
      col_q <= col_q + 1'b1;
      if (16'(col_q) == last_col_i) busy_q <= 1'b0;
    end
  end

  // last column of a macroblock completes the window
  assign load_o   = busy_q && (col_q[MW-1:0] == MW'(MB_W-1));
  assign rd_col_o = col_q;
  assign busy_o   = busy_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [RW_BITS-1:0] win_q, win_n, hold_q;
    // newest sample enters at the top byte, so byte i ends as offset i
    assign win_n = {col_data_i[r*PIX_W +: PIX_W], win_q[RW_BITS-1:PIX_W]};
    always_ff @(posedge clk_i) begin
      if (busy_q) win_q <= win_n;
      if (load_o) hold_q <= win_n;
    end
    assign hold_o[r*RW_BITS +: RW_BITS] = hold_q;
  end
endmodule

// File: rtl/chroma_sub_emit.sv
module chroma_sub_emit
  import chroma_framer_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int OUT_W = SUB_N*SUB_N*PIX_W,
  localparam int HOLD_W = C_ROWS*MB_W*PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             comp_o,
  output logic [1:0]       sub_o,
  output logic [OUT_W-1:0] data_o
);
  logic       act_q;
  logic [2:0] cnt_q;   // [2] component, [1] lower half, [0] right half
  logic [OUT_W-1:0] sel;
  comp_e      comp_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      cnt_q <= cnt_q + 3'd1;
      if (cnt_q == 3'd7) act_q <= 1'b0;
    end
  end

  // each output byte picks among 8 fixed window positions
  for (genvar r = 0; r < SUB_N; r++) begin : g_r
    for (genvar c = 0; c < SUB_N; c++) begin : g_c
      logic [PIX_W-1:0] cand [8];
      for (genvar k = 0; k < 8; k++) begin : g_k
        localparam int ROW = SUB_N*((k >> 1) & 1) + r;
        localparam int COL = 2*(SUB_N*(k & 1) + c) + (k >> 2);
        assign cand[k] = hold_i[(ROW*MB_W + COL)*PIX_W +: PIX_W];
      end
      assign sel[(SUB_N*r + c)*PIX_W +: PIX_W] = cand[cnt_q];
    end
  end

  assign comp_n = cnt_q[2] ? COMP_CR : COMP_CB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      comp_o  <= 1'b0;
      sub_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= act_q;
      if (act_q) begin
        comp_o <= comp_n;
        sub_o  <= cnt_q[1:0];
        data_o <= sel;
      end else begin
        comp_o <= 1'b0;
        sub_o  <= '0;
      end
    end
  end

  assign busy_o = act_q;
endmodule

// File: rtl/chroma_420_framer.sv
module chroma_420_framer
  import chroma_framer_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MAX_W = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PIX_W-1:0]            c_data_i,
  input  logic                        c_valid_i,
  input  logic                        frame_start_i,
  input  logic                        frame_end_i,
  input  logic [15:0]                 hres_i,
  input  logic [15:0]                 vres_i,
  output logic                        blk_valid_o,
  output logic                        blk_comp_o,
  output logic [1:0]                  blk_sub_o,
  output logic [SUB_N*SUB_N*PIX_W-1:0] blk_data_o
);
  localparam int XW = $clog2(MAX_W);
  localparam int RW = $clog2(C_ROWS);
  localparam int SW = RW + 1;               // strip line bits
  localparam int HOLD_W = C_ROWS*MB_W*PIX_W;

  logic        fs_q, in_frame_q;
  logic [15:0] x_q, line_q, x_cur, line_cur, hres_m1;
  logic        fs_rise, accept, eol, eof, strip_done;
  logic        wr_en;
  logic [XW-1:0] rd_col;
  logic [C_ROWS*PIX_W-1:0] col_data;
  logic        rd_busy, hold_load, emit_busy;
  logic [HOLD_W-1:0] hold;

  assign fs_rise  = frame_start_i & ~fs_q;
  assign accept   = c_valid_i & (in_frame_q | fs_rise);
  assign x_cur    = fs_rise ? 16'd0 : x_q;
  assign line_cur = fs_rise ? 16'd0 : line_q;
  assign hres_m1  = hres_i - 16'd1;
  assign eol      = accept && (x_cur == hres_m1);
  assign eof      = eol && (line_cur == vres_i - 16'd1);
  // last kept line of the strip completes the store
  assign strip_done = eol && (line_cur[SW-1:0] == SW'(2*C_ROWS-2));
  assign wr_en    = accept && !line_cur[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q       <= 1'b0;
      in_frame_q <= 1'b0;
      x_q        <= '0;
      line_q     <= '0;
    end else begin
      fs_q <= frame_start_i;
      if (accept)       x_q <= eol ? 16'd0 : x_cur + 16'd1;
      else if (fs_rise) x_q <= 16'd0;
      if (eol)          line_q <= line_cur + 16'd1;
      else if (fs_rise) line_q <= 16'd0;
      if (fs_rise)                  in_frame_q <= 1'b1;
      else if (eof || frame_end_i)  in_frame_q <= 1'b0;
    end
  end

  chroma_line_store #(
    .PIX_W(PIX_W), .MAX_W(MAX_W), .ROWS(C_ROWS)
  ) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_row_i  (line_cur[RW:1]),
    .wr_col_i  (x_cur[XW-1:0]),
    .wr_data_i (c_data_i),
    .rd_col_i  (rd_col),
    .rd_data_o (col_data)
  );

  chroma_window #(
    .PIX_W(PIX_W), .MAX_W(MAX_W), .ROWS(C_ROWS), .MB_W(MB_W)
  ) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (strip_done),
    .last_col_i (hres_m1),
    .col_data_i (col_data),
    .rd_col_o   (rd_col),
    .busy_o     (rd_busy),
    .load_o     (hold_load),
    .hold_o     (hold)
  );

  chroma_sub_emit #(
    .PIX_W(PIX_W)
  ) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (hold_load),
    .hold_i  (hold),
    .busy_o  (emit_busy),
    .valid_o (blk_valid_o),
    .comp_o  (blk_comp_o),
    .sub_o   (blk_sub_o),
    .data_o  (blk_data_o)
  );
endmodule

// File: rtl/chroma_framer_chk.sv
module chroma_framer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       blk_valid_o,
  input logic       blk_comp_o,
  input logic [1:0] blk_sub_o,
  input logic       strip_done,
  input logic       rd_busy,
  input logic       hold_load,
  input logic       emit_busy
);
  // R4: quadrants advance by one on consecutive valid cycles
  p_sub_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_o && $past(blk_valid_o)) |-> (blk_sub_o == 2'($past(blk_sub_o) + 2'd1)));

  // R4: component changes only after quadrant 3
  p_comp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_o && $past(blk_valid_o) && $past(blk_sub_o) != 2'd3)
      |-> (blk_comp_o == $past(blk_comp_o)));

  // R4: a burst opens with blue top-left
  p_burst_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_valid_o) |-> (blk_sub_o == 2'd0 && !blk_comp_o));

  // R4: a burst closes after red bottom-right
  p_burst_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_o && blk_comp_o && blk_sub_o == 2'd3) |=> !blk_valid_o);

  // R10: a new strip never starts while the reader still walks the last one
  p_no_overrun_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strip_done |-> !rd_busy);

  // R10: the hold register is never reloaded under a running burst
  p_hold_free_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_load |-> !emit_busy);
endmodule

bind chroma_420_framer chroma_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blk_valid_o (blk_valid_o),
  .blk_comp_o  (blk_comp_o),
  .blk_sub_o   (blk_sub_o),
  .strip_done  (strip_done),
  .rd_busy     (rd_busy),
  .hold_load   (hold_load),
  .emit_busy   (emit_busy)
);

// File: tb/tb_chroma_420_framer.sv
`timescale 1ns/1ps
module tb_chroma_420_framer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   c_data = '0;
  logic         c_valid = 1'b0;
  logic         fs = 1'b0;
  logic         fe = 1'b0;
  logic [15:0]  hres = 16'd16;
  logic [15:0]  vres = 16'd16;
  logic         blk_valid, blk_comp;
  logic [1:0]   blk_sub;
  logic [127:0] blk_data;

  int checks = 0;
  int errors = 0;

  logic [127:0] cap_d [256];
  logic         cap_c [256];
  logic [1:0]   cap_s [256];
  int           cap_n = 0;

  always #2.5 clk = ~clk;

  chroma_420_framer dut (
    .clk_i(clk), .rst_ni(rst_n), .c_data_i(c_data), .c_valid_i(c_valid),
    .frame_start_i(fs), .frame_end_i(fe), .hres_i(hres), .vres_i(vres),
    .blk_valid_o(blk_valid), .blk_comp_o(blk_comp), .blk_sub_o(blk_sub),
    .blk_data_o(blk_data)
  );

  always @(negedge clk) begin
    if (rst_n && blk_valid) begin
      if (cap_n < 256) begin
        cap_d[cap_n] = blk_data;
        cap_c[cap_n] = blk_comp;
        cap_s[cap_n] = blk_sub;
      end
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [7:0] pix(int seed, int salt, int x, int y);
    if (y % 2 == 1) return 8'((x*5 + y*3 + salt) ^ 255);
    return 8'(x*11 + y*29 + seed*7);
  endfunction

  function automatic logic [127:0] exp_blk(int seed, int s, int k, int c, int q);
    logic [127:0] v = '0;
    for (int r = 0; r < 4; r++)
      for (int cc = 0; cc < 4; cc++)
        v[8*(4*r+cc) +: 8] = pix(seed, 0, 16*k + 2*(4*(q % 2) + cc) + c,
                                 16*s + 2*(4*(q / 2) + r));
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_frame(int w, int h_sent, int v, int seed, int salt,
                            int gap_every, int fs_hold);
    int n = 0;
    hres = 16'(w);
    vres = 16'(v);
    for (int y = 0; y < h_sent; y++) begin
      for (int x = 0; x < w; x++) begin
        if (gap_every != 0 && (n % gap_every) == gap_every - 1) begin
          c_valid = 1'b0;
          fs = (n < fs_hold);
          @(negedge clk);
        end
        c_valid = 1'b1;
        c_data  = pix(seed, salt, x, y);
        fs      = (n < fs_hold);
        n++;
        @(negedge clk);
      end
    end
    c_valid = 1'b0;
    fs = 1'b0;
  endtask

  task automatic send_junk(int n, bit fs_level);
    for (int i = 0; i < n; i++) begin
      c_valid = 1'b1;
      c_data  = 8'(i*37 + 101);
      fs      = fs_level;
      @(negedge clk);
    end
    c_valid = 1'b0;
  endtask

  task automatic check_out(int w, int h, int seed, string tag);
    int n_exp = (w/16)*(h/16)*8;
    chk(cap_n == n_exp, {tag, " R6 count"}, 128'(cap_n), 128'(n_exp));
    for (int i = 0; i < n_exp && i < cap_n; i++) begin
      int s = i / ((w/16)*8);
      int k = (i / 8) % (w/16);
      int c = (i / 4) % 2;
      int q = i % 4;
      chk(cap_c[i] == 1'(c) && cap_s[i] == 2'(q), {tag, " R4 tags"},
          128'({cap_c[i], cap_s[i]}), 128'({1'(c), 2'(q)}));
      chk(cap_d[i] == exp_blk(seed, s, k, c, q), {tag, " R2 R3 R5 data"},
          cap_d[i], exp_blk(seed, s, k, c, q));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!blk_valid && !blk_comp && blk_sub == 2'd0, "R1 reset outputs",
        128'({blk_valid, blk_comp, blk_sub}), 128'(0));
    repeat (20) @(negedge clk);
    chk(cap_n == 0, "R1 no output before strip", 128'(cap_n), 128'(0));
  endtask

  task automatic t_single_mb();
    cap_n = 0;
    send_frame(16, 16, 16, 3, 90, 0, 1);
    repeat (60) @(negedge clk);
    check_out(16, 16, 3, "single");
  endtask

  task automatic t_wide_full_rate();
    cap_n = 0;
    send_frame(64, 32, 32, 11, 17, 0, 1);  // R10 back-to-back lines and strips
    repeat (120) @(negedge clk);
    check_out(64, 32, 11, "R10 wide");
  endtask

  task automatic t_odd_lines();
    cap_n = 0;
    send_frame(32, 16, 16, 5, 201, 0, 1);  // R3 odd-line pattern changed
    repeat (80) @(negedge clk);
    check_out(32, 16, 5, "R3 odd");
  endtask

  task automatic t_stalls();
    cap_n = 0;
    send_frame(32, 32, 32, 7, 44, 3, 1);   // R9 idle every third slot
    repeat (100) @(negedge clk);
    check_out(32, 32, 7, "R9 stall");
  endtask

  task automatic t_restart();
    cap_n = 0;
    hres = 16'd16;
    vres = 16'd16;
    send_junk(20, 1'b1);                   // R7 level held, partial frame
    fs = 1'b0;
    @(negedge clk);
    send_frame(16, 16, 16, 9, 3, 0, 5);
    repeat (60) @(negedge clk);
    check_out(16, 16, 9, "R7 restart");
  endtask

  task automatic t_after_last_line();
    cap_n = 0;
    send_frame(16, 16, 16, 13, 8, 0, 1);
    send_junk(256, 1'b0);                  // R8 past last line
    repeat (60) @(negedge clk);
    check_out(16, 16, 13, "R8 eof");
  endtask

  task automatic t_frame_end();
    cap_n = 0;
    send_frame(16, 16, 32, 21, 66, 0, 1);
    fe = 1'b1;
    @(negedge clk);
    fe = 1'b0;
    send_junk(256, 1'b0);                  // R8 after end pulse
    repeat (60) @(negedge clk);
    check_out(16, 16, 21, "R8 end pulse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_mb();
    t_wide_full_rate();
    t_odd_lines();
    t_stalls();
    t_restart();
    t_after_last_line();
    t_frame_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule